// File: doc/BRIEF.md
# Two-Zone Latched Intrusion Alarm

This block turns two momentary sensor contacts and one arming switch into a steady alarm signal. Each sensor closes for a short time, from about half a second to two seconds, and then reopens. A plain combinational gate would drop the alarm as soon as the contact reopens. This block instead gives each zone its own sticky flag. A qualified sensor pulse sets the flag while the system is armed. The flag then stays set until the arming switch opens. The alarm output is high whenever either zone flag is set.

All three inputs are asynchronous switch levels, active high, meaning the switch is closed. Each input first passes through a two-flop synchronizer. A sensor then has to pass a debounce counter: it must read high for `DEBOUNCE_CYCLES` consecutive clock cycles before it counts as a trip. The arming line is never used as a clock or as an asynchronous reset. It only acts as a synchronous clear, and while it is low both flags are held at zero. A synchronous active-high system reset clears every flop in the block.

Top module: `twozone_alarm`

## Requirements
- R1: While `rst` is high at a clock edge, both `zone_tripped` bits and `alarm_out` are 0 after that edge, including when a zone had tripped beforehand.
- R2: A sensor pulse counts only if the raw input is high at `DEBOUNCE_CYCLES` or more consecutive rising edges. Shorter pulses have no effect, and so does a bouncing input whose high runs are all shorter than `DEBOUNCE_CYCLES`.
- R3: Count the first rising edge that samples a sensor high as edge 1. With the block armed, that zone's `zone_tripped` bit is still 0 after edge `DEBOUNCE_CYCLES+2` and is 1 after edge `DEBOUNCE_CYCLES+3`.
- R4: Once a zone bit is set, it stays 1 after the sensor returns low, for as long as the arming input stays high.
- R5: `alarm_out` is the OR of the two `zone_tripped` bits. Bit 0 belongs to `sensor_in[0]` and bit 1 belongs to `sensor_in[1]`.
- R6: A sensor pulse that arrives while the arming input is low sets nothing. The alarm follows arm AND (zone0 OR zone1).
- R7: Count the first rising edge that samples `arm_in` low as edge 1. Both zone bits are still set after edge 2 and are 0 after edge 3. They then stay 0 for as long as `arm_in` is low.
- R8: A clear always beats a set. A sensor held high and fully qualified while the arming input is low leaves its zone bit at 0.
- R9: If a sensor is still held high when `arm_in` rises, its zone bit becomes 1 after the third rising edge that samples `arm_in` high. It is still 0 after the second.
- R10: The zones are independent. A pulse on one sensor sets only that zone's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| arm_in | input | 1 | Raw arming switch level; high means armed, low clears and holds clear |
| sensor_in | input | NUM_ZONES | Raw sensor contact levels, one bit per zone, high when closed |
| zone_tripped | output | NUM_ZONES | Sticky per-zone trip flags |
| alarm_out | output | 1 | OR of all zone trip flags |

## Verification
A wrong debounce count shows up at the ports as a zone bit that rises one cycle early or late compared with the fixed latency. It can also show up as a pulse one cycle too short being accepted, so pulse lengths are swept around the threshold. A flag that fails to hold drops `alarm_out` within one cycle after the sensor pulse ends, and a clear that fails to win leaves a bit high three cycles after disarming. Every combination of arm level and sensor pulses is swept, and each zone bit is compared separately so that a crossed zone mapping is caught.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    // Default debounce length: 10 ms at a 100 MHz clock.
    localparam int unsigned DEF_DEBOUNCE_CYCLES = 1_000_000;
    localparam int unsigned DEF_SYNC_STAGES     = 2;
    localparam int unsigned DEF_NUM_ZONES       = 2;

    // Per-zone control inputs seen by the sticky flag.
    typedef struct packed {
        logic armed;      // synchronized arming level
        logic qualified;  // debounced sensor level
    } zone_ctl_t;

    // Width needed to hold values 0..limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    // Saturating increment toward a limit.
    function automatic int unsigned sat_step(input int unsigned cur,
                                             input int unsigned limit);
        return (cur >= limit) ? limit : cur + 1;
    endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("alarm_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[LAST];

endmodule

// File: rtl/alarm_debounce.sv
module alarm_debounce
    import alarm_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = DEF_DEBOUNCE_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic qualified
);
    localparam int unsigned CW = cnt_width(DEBOUNCE_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_CYCLES);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (!level_in) begin
            run_len <= '0;
        end else begin
            run_len <= CW'(sat_step(int'(run_len), DEBOUNCE_CYCLES));
        end
    end

    assign qualified = (run_len == LIMIT);

    assert_run_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        run_len <= LIMIT);

    assert_low_drops_qual_R2: assert property (@(posedge clk) disable iff (rst)
        !level_in |=> !qualified);

endmodule

// File: rtl/alarm_zone.sv
module alarm_zone
    import alarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  zone_ctl_t ctl,
    output logic      tripped
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (!ctl.armed) begin
            flag_q <= 1'b0;           // clear beats set
        end else if (ctl.qualified) begin
            flag_q <= 1'b1;
        end
    end

    assign tripped = flag_q;

    assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl.armed |=> !tripped);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.armed && tripped) |=> tripped);

    assert_set_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tripped) |-> ($past(ctl.armed) && $past(ctl.qualified)));

endmodule

// File: rtl/twozone_alarm.sv
module twozone_alarm
    import alarm_pkg::*;
#(
    parameter int unsigned NUM_ZONES       = DEF_NUM_ZONES,
    parameter int unsigned SYNC_STAGES     = DEF_SYNC_STAGES,
    parameter int unsigned DEBOUNCE_CYCLES = DEF_DEBOUNCE_CYCLES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm_in,
    input  logic [NUM_ZONES-1:0] sensor_in,
    output logic [NUM_ZONES-1:0] zone_tripped,
    output logic                 alarm_out
);
    localparam int unsigned SW = NUM_ZONES + 1;

    logic [SW-1:0]        raw_bus;
    logic [SW-1:0]        sync_bus;
    logic                 arm_s;
    logic [NUM_ZONES-1:0] sens_s;
    logic [NUM_ZONES-1:0] sens_q;

    assign raw_bus = {arm_in, sensor_in};

    alarm_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (raw_bus),
        .q_sync  (sync_bus)
    );

    assign arm_s  = sync_bus[SW-1];
    assign sens_s = sync_bus[NUM_ZONES-1:0];

    generate
        for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
            zone_ctl_t ctl;

            alarm_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
                .clk       (clk),
                .rst       (rst),
                .level_in  (sens_s[z]),
                .qualified (sens_q[z])
            );

            assign ctl.armed     = arm_s;
            assign ctl.qualified = sens_q[z];

            alarm_zone u_zone (
                .clk     (clk),
                .rst     (rst),
                .ctl     (ctl),
                .tripped (zone_tripped[z])
            );
        end
    endgenerate

    assign alarm_out = |zone_tripped;

    assert_alarm_rise_armed_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_out) |-> $past(arm_s));

    assert_qual_disarmed_stays_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!arm_s && |sens_q) |=> !alarm_out);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (zone_tripped == '0));

endmodule

// File: tb/twozone_alarm_bench.sv
module twozone_alarm_bench;

    localparam int NZ  = 2;
    localparam int DEB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm_in = 1'b0;
    logic [NZ-1:0] sensor_in = '0;
    logic [NZ-1:0] zone_tripped;
    logic          alarm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    twozone_alarm #(.NUM_ZONES(NZ), .SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB)) u_twozone_alarm (
        .clk          (clk),
        .rst          (rst),
        .arm_in       (arm_in),
        .sensor_in    (sensor_in),
        .zone_tripped (zone_tripped),
        .alarm_out    (alarm_out)
    );

    // Advance n rising edges, then settle at the falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NZ:0] act, input logic [NZ:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {alarm,zones} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NZ:0] expect_of(input logic [NZ-1:0] z);
        return {|z, z};
    endfunction

    task automatic clear_and_arm();
        arm_in = 1'b0; sensor_in = '0;
        step(DEB + 4);
        arm_in = 1'b1;
        step(4);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        step(3);
        check("R1 reset", {alarm_out, zone_tripped}, '0);
        rst = 1'b0;
        step(1);

        // R3: exact latency on zone 0
        clear_and_arm();
        sensor_in = 2'b01;
        step(DEB + 2);
        check("R3 before", {alarm_out, zone_tripped}, '0);
        step(1);
        check("R3 after", {alarm_out, zone_tripped}, expect_of(2'b01));
        sensor_in = '0;
        step(6);
        check("R4 sticky", {alarm_out, zone_tripped}, expect_of(2'b01));

        // R7: clear timing after disarm
        arm_in = 1'b0;
        step(2);
        check("R7 still set", {alarm_out, zone_tripped}, expect_of(2'b01));
        step(1);
        check("R7 cleared", {alarm_out, zone_tripped}, '0);
        step(10);
        check("R7 held clear", {alarm_out, zone_tripped}, '0);

        // R1: mid-run reset clears a tripped zone
        clear_and_arm();
        sensor_in = 2'b10;
        step(DEB + 4);
        sensor_in = '0;
        check("R10 zone1 only", {alarm_out, zone_tripped}, expect_of(2'b10));
        rst = 1'b1;
        step(2);
        check("R1 mid-run", {alarm_out, zone_tripped}, '0);
        rst = 1'b0;
        step(1);

        // Sweep arm x sensor pulses: R4 R5 R6 R10
        for (int combo = 0; combo < 8; combo++) begin
            logic a;
            logic [NZ-1:0] s;
            logic [NZ-1:0] ez;
            a = combo[2];
            s = combo[1:0];
            arm_in = 1'b0; sensor_in = '0;
            step(DEB + 4);
            arm_in = a;
            step(4);
            sensor_in = s;
            step(DEB + 1);
            sensor_in = '0;
            step(8);
            ez = a ? s : '0;
            check(a ? "R4 R5 R10 sweep" : "R6 disarmed sweep", {alarm_out, zone_tripped}, expect_of(ez));
            if (a) begin
                arm_in = 1'b0;
                step(3);
                check("R7 sweep clear", {alarm_out, zone_tripped}, '0);
            end
        end

        // R2: pulse length sweep around the threshold
        for (int p = 1; p <= DEB + 2; p++) begin
            clear_and_arm();
            sensor_in = 2'b01;
            step(p);
            sensor_in = '0;
            step(DEB + 6);
            check("R2 pulse length", {alarm_out, zone_tripped},
                  expect_of((p >= DEB) ? 2'b01 : 2'b00));
        end

        // R2: bounce with runs shorter than threshold
        clear_and_arm();
        for (int b = 0; b < 5; b++) begin
            sensor_in = 2'b11;
            step(DEB - 1);
            sensor_in = '0;
            step(1);
        end
        step(DEB + 4);
        check("R2 bounce", {alarm_out, zone_tripped}, '0);

        // R8: qualified sensor while disarmed, then R9 re-arm
        arm_in = 1'b0; sensor_in = 2'b10;
        step(DEB + 10);
        check("R8 clear wins", {alarm_out, zone_tripped}, '0);
        arm_in = 1'b1;
        step(2);
        check("R9 before", {alarm_out, zone_tripped}, '0);
        step(1);
        check("R9 after", {alarm_out, zone_tripped}, expect_of(2'b10));
        sensor_in = '0;
        step(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule